// File: doc/BRIEF.md
# Two-Wire Bus Slave Controller with Promiscuous and Smart Modes

This block is a 7-bit-address slave for a two-wire serial bus (clock line and data line, both open drain), controlled by a CPU through a small register file. It recognises START and STOP conditions on the bus and compares each address byte either with its own programmed address or, in promiscuous mode, accepts every address. After a matched address and after every data byte it sets a flag and holds the clock line low. The bus then waits until software has decided how to answer: acknowledge, refuse, supply the next byte to send, or drop out of the transfer.

Software answers through a command field, by writing one to the flag that caused the hold, or through the data register. Writing the data register while a byte to send is awaited loads the byte and restarts the bus. In smart mode, reading a received byte is enough: the acknowledge or refusal chosen beforehand goes out at once. An interrupt request is formed from the two flags, each with its own enable, and is gated by a two-bit priority level field that must be nonzero. The bus inputs are resynchronised to the block clock, and the outputs are active-high pull-down enables for the two lines.

Register map (offset on `reg_sel`): 0 = CTRLA, 1 = CTRLB, 2 = STATUS, 3 = ADDR, 4 = DATA. CTRLA bit fields: [7:6] interrupt level, [5] data interrupt enable, [4] address/stop interrupt enable, [3] enable, [2] stop flag enable, [1] promiscuous, [0] smart. CTRLB: [2] ACKACT (0 = acknowledge, 1 = refuse), [1:0] command (write-only). STATUS: [0] DIF, [1] APIF, [2] clock held, [3] R/W bit of the last address, [4] APIF cause (1 = address, 0 = STOP), [5] master refused the last sent byte. ADDR: [6:0] own address.

Top module: `twb_slave`

## Requirements
- R1: After reset CTRLA, CTRLB and STATUS read 0x00, neither line is pulled low and `irq` is 0.
- R2: CTRLB bits 7:3 and the command bits 1:0 always read zero; bit 2 (ACKACT) reads back what was written. Command 2'b11 answers the current hold and 2'b10 abandons the transfer; commands written while no hold is pending have no effect.
- R3: The 7 address bits received first are compared with ADDR[6:0], which reads back as written. On a match APIF, STATUS bit 4 and STATUS bit 2 are set, STATUS bit 3 takes the received R/W bit and the clock line is held low.
- R4: A non-matching address with promiscuous mode off sets no flag, does not hold the clock and is not acknowledged (data line high in the ninth clock).
- R5: With CTRLA bit 1 set, any address is treated as a match.
- R6: When a hold is answered, the slave pulls the data line low in the ninth clock if ACKACT is 0 and leaves it high if ACKACT is 1; after a refusal it ignores the bus until the next START.
- R7: After each received data byte DIF is set, the clock is held, DATA returns the byte, and writing 1 to STATUS bit 0 (or bit 1 for an address hold) clears that flag and answers the hold.
- R8: With CTRLA bit 0 set, reading DATA during a receive hold answers it with ACKACT; with bit 0 clear the read leaves the clock held.
- R9: On a read address, the slave holds the clock with DIF set before each byte; writing DATA loads the byte and releases the clock, and it is sent most significant bit first. A master acknowledge leads to the next hold; a master refusal sets STATUS bit 5 and ends the transfer.
- R10: A STOP sets APIF with STATUS bit 4 clear only when CTRLA bit 2 is set; STATUS bit 4 is cleared by any STOP.
- R11: `irq` is 1 exactly when CTRLA[7:6] is nonzero and (DIF with CTRLA bit 5, or APIF with CTRLA bit 4).
- R12: While CTRLA bit 3 is clear, both lines are released, STATUS reads 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_scl_i | input | 1 | Sensed level of the bus clock line |
| bus_sda_i | input | 1 | Sensed level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (hold) |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a hold in the middle of a transfer that is answered while the master has already released the clock line, because the bus side and the register side must interleave. The bench splits every ninth or stretched bit into a release phase and a completion phase. Between them it observes the held line, reads STATUS and answers by command, flag clear, data write or smart read. A repeated START into a read transfer, a master refusal and a disable during a hold are reached the same way.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int DW     = 8;
  localparam int AW     = DW - 1;
  localparam int CW     = $clog2(DW + 1);
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_CTRLA  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTRLB  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_STATUS = 3'd2;
  localparam logic [REG_AW-1:0] OFS_ADDR   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_DATA   = 3'd4;

  localparam logic [1:0] CMD_QUIT = 2'b10;
  localparam logic [1:0] CMD_RESP = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AHOLD, ST_ACK, ST_RX, ST_RHOLD,
    ST_THOLD, ST_TX, ST_TACK
  } twb_state_e;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_c, sda_c;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_c[0] <= 1'b1;
      sda_c[0] <= 1'b1;
    end else begin
      scl_c[0] <= scl_i;
      sda_c[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_c[g] <= 1'b1;
        sda_c[g] <= 1'b1;
      end else begin
        scl_c[g] <= scl_c[g-1];
        sda_c[g] <= sda_c[g-1];
      end
    end
  end

  assign scl_s = scl_c[STAGES-1];
  assign sda_s = sda_c[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_p   = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/twb_regs.sv
module twb_regs
  import twb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic              dif,
  input  logic              apif,
  input  logic              hold,
  input  logic              dir,
  input  logic              ap_addr,
  input  logic              mnack,
  input  logic [DW-1:0]     rx_byte,
  output logic              en,
  output logic              prom,
  output logic              smart,
  output logic              pien,
  output logic [1:0]        int_lvl,
  output logic              ackact,
  output logic [AW-1:0]     own_addr,
  output logic              cmd_resp,
  output logic              cmd_quit,
  output logic              clr_dif,
  output logic              clr_apif,
  output logic              data_rd,
  output logic              data_wr,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  logic [DW-1:0] ctrla_q, ctrla_n;
  logic          ackact_q, ackact_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          wr_a, wr_b, wr_s, wr_ad, wr_d;

  always_comb begin
    wr_a  = wr && (sel == OFS_CTRLA);
    wr_b  = wr && (sel == OFS_CTRLB);
    wr_s  = wr && (sel == OFS_STATUS);
    wr_ad = wr && (sel == OFS_ADDR);
    wr_d  = wr && (sel == OFS_DATA);
  end

  always_comb begin
    ctrla_n  = wr_a  ? wdata : ctrla_q;
    ackact_n = wr_b  ? wdata[2] : ackact_q;
    addr_n   = wr_ad ? wdata[AW-1:0] : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrla_q  <= '0;
      ackact_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      if (wr_a)  ctrla_q  <= ctrla_n;
      if (wr_b)  ackact_q <= ackact_n;
      if (wr_ad) addr_q   <= addr_n;
    end
  end

  assign int_lvl  = ctrla_q[7:6];
  assign en       = ctrla_q[3];
  assign pien     = ctrla_q[2];
  assign prom     = ctrla_q[1];
  assign smart    = ctrla_q[0];
  assign ackact   = ackact_q;
  assign own_addr = addr_q;

  assign cmd_resp = wr_b && (wdata[1:0] == CMD_RESP);
  assign cmd_quit = wr_b && (wdata[1:0] == CMD_QUIT);
  assign clr_dif  = wr_s && wdata[0];
  assign clr_apif = wr_s && wdata[1];
  assign data_wr  = wr_d;
  assign data_rd  = rd && (sel == OFS_DATA);

  always_comb begin
    case (sel)
      OFS_CTRLA:  rdata = ctrla_q;
      OFS_CTRLB:  rdata = {5'b00000, ackact_q, 2'b00};
      OFS_STATUS: rdata = {2'b00, mnack, ap_addr, dir, hold, apif, dif};
      OFS_ADDR:   rdata = {1'b0, addr_q};
      OFS_DATA:   rdata = rx_byte;
      default:    rdata = '0;
    endcase
  end

  assign irq = (int_lvl != 2'b00) &&
               ((ctrla_q[5] && dif) || (ctrla_q[4] && apif));
endmodule

// File: rtl/twb_engine.sv
module twb_engine
  import twb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          prom,
  input  logic          smart,
  input  logic          ackact,
  input  logic          pien,
  input  logic [AW-1:0] own_addr,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          sda_s,
  input  logic          cmd_resp,
  input  logic          cmd_quit,
  input  logic          clr_dif,
  input  logic          clr_apif,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          dif,
  output logic          apif,
  output logic          ap_addr,
  output logic          dir,
  output logic          mnack,
  output logic [DW-1:0] rx_byte
);
  twb_state_e    st_q, st_n;
  logic [DW-1:0] sh_q, sh_n, txb_q, rx_q, src;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sda_q, sda_n, acked_q, acked_n;
  logic          dif_q, dif_n, apif_q, apif_n;
  logic          apa_q, apa_n, dir_q, dir_n, mn_q, mn_n;
  logic          rx_ld, release_ev, last_bit;

  always_comb begin
    release_ev = cmd_resp
               | ((st_q == ST_AHOLD) & clr_apif)
               | (((st_q == ST_RHOLD) | (st_q == ST_THOLD)) & clr_dif)
               | ((st_q == ST_RHOLD) & smart & data_rd)
               | ((st_q == ST_THOLD) & data_wr);
    src      = data_wr ? wdata : txb_q;
    last_bit = (cnt_q == CW'(DW));
  end

  always_comb begin
    st_n = st_q; sh_n = sh_q; cnt_n = cnt_q; sda_n = sda_q;
    acked_n = acked_q; dir_n = dir_q; apa_n = apa_q; mn_n = mn_q;
    dif_n  = dif_q  & ~clr_dif;
    apif_n = apif_q & ~clr_apif;
    rx_ld  = 1'b0;
    case (st_q)
      ST_ADDR: begin
        if (scl_rise) begin
          sh_n  = {sh_q[DW-2:0], sda_s};
          cnt_n = cnt_q + 1'b1;
        end else if (scl_fall && last_bit) begin
          if (prom || (sh_q[DW-1:1] == own_addr)) begin
            apif_n = 1'b1;
            apa_n  = 1'b1;
            dir_n  = sh_q[0];
            st_n   = ST_AHOLD;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_AHOLD, ST_RHOLD: begin
        if (cmd_quit) begin
          st_n = ST_IDLE;
        end else if (release_ev) begin
          sda_n   = ~ackact;
          acked_n = ~ackact;
          st_n    = ST_ACK;
          if (st_q == ST_AHOLD) apif_n = 1'b0;
          else                  dif_n  = 1'b0;
        end
      end
      ST_ACK: begin
        if (scl_fall) begin
          sda_n = 1'b0;
          if (!acked_q) begin
            st_n = ST_IDLE;
          end else if (dir_q) begin
            dif_n = 1'b1;
            st_n  = ST_THOLD;
          end else begin
            cnt_n = '0;
            st_n  = ST_RX;
          end
        end
      end
      ST_RX: begin
        if (scl_rise) begin
          sh_n  = {sh_q[DW-2:0], sda_s};
          cnt_n = cnt_q + 1'b1;
        end else if (scl_fall && last_bit) begin
          rx_ld = 1'b1;
          dif_n = 1'b1;
          st_n  = ST_RHOLD;
        end
      end
      ST_THOLD: begin
        if (cmd_quit) begin
          dif_n = 1'b0;
          st_n  = ST_IDLE;
        end else if (release_ev) begin
          sh_n  = src;
          sda_n = ~src[DW-1];
          cnt_n = CW'(1);
          dif_n = 1'b0;
          st_n  = ST_TX;
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          if (last_bit) begin
            sda_n = 1'b0;
            st_n  = ST_TACK;
          end else begin
            sda_n = ~sh_q[DW-1-int'(cnt_q)];
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_TACK: begin
        if (scl_rise) begin
          mn_n = sda_s;
        end else if (scl_fall) begin
          if (mn_q) begin
            st_n = ST_IDLE;
          end else begin
            dif_n = 1'b1;
            st_n  = ST_THOLD;
          end
        end
      end
      default: ;
    endcase

    if (start_p) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      sda_n = 1'b0;
      mn_n  = 1'b0;
    end else if (stop_p) begin
      st_n  = ST_IDLE;
      sda_n = 1'b0;
      apa_n = 1'b0;
      if (pien) apif_n = 1'b1;
    end

    if (!en) begin
      st_n = ST_IDLE; sda_n = 1'b0; dif_n = 1'b0; apif_n = 1'b0;
      apa_n = 1'b0; dir_n = 1'b0; mn_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      sda_q   <= 1'b0;
      acked_q <= 1'b0;
      dif_q   <= 1'b0;
      apif_q  <= 1'b0;
      apa_q   <= 1'b0;
      dir_q   <= 1'b0;
      mn_q    <= 1'b0;
      txb_q   <= '0;
      rx_q    <= '0;
    end else begin
      st_q    <= st_n;
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
      sda_q   <= sda_n;
      acked_q <= acked_n;
      dif_q   <= dif_n;
      apif_q  <= apif_n;
      apa_q   <= apa_n;
      dir_q   <= dir_n;
      mn_q    <= mn_n;
      if (data_wr) txb_q <= wdata;
      if (rx_ld)   rx_q  <= sh_q;
    end
  end

  assign scl_oe  = (st_q == ST_AHOLD) || (st_q == ST_RHOLD) || (st_q == ST_THOLD);
  assign sda_oe  = sda_q;
  assign dif     = dif_q;
  assign apif    = apif_q;
  assign ap_addr = apa_q;
  assign dir     = dir_q;
  assign mnack   = mn_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/twb_slave.sv
module twb_slave
  import twb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_scl_i,
  input  logic              bus_sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic en, prom, smart, pien, ackact;
  logic [1:0] int_lvl;
  logic [AW-1:0] own_addr;
  logic cmd_resp, cmd_quit, clr_dif, clr_apif, data_rd, data_wr;
  logic dif, apif, ap_addr, dir, mnack;
  logic [DW-1:0] rx_byte;

  twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(bus_scl_i), .sda_i(bus_sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  twb_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .dif(dif), .apif(apif), .hold(scl_oe), .dir(dir),
    .ap_addr(ap_addr), .mnack(mnack), .rx_byte(rx_byte), .en(en),
    .prom(prom), .smart(smart), .pien(pien), .int_lvl(int_lvl),
    .ackact(ackact), .own_addr(own_addr), .cmd_resp(cmd_resp),
    .cmd_quit(cmd_quit), .clr_dif(clr_dif), .clr_apif(clr_apif),
    .data_rd(data_rd), .data_wr(data_wr), .rdata(reg_rdata), .irq(irq)
  );

  twb_engine u_eng (
    .clk(clk), .rst_n(rst_n_s), .en(en), .prom(prom), .smart(smart),
    .ackact(ackact), .pien(pien), .own_addr(own_addr),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p),
    .stop_p(stop_p), .sda_s(sda_s), .cmd_resp(cmd_resp),
    .cmd_quit(cmd_quit), .clr_dif(clr_dif), .clr_apif(clr_apif),
    .data_rd(data_rd), .data_wr(data_wr), .wdata(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .dif(dif), .apif(apif),
    .ap_addr(ap_addr), .dir(dir), .mnack(mnack), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/twb_slave_chk.sv
module twb_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] int_lvl,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       dif,
  input logic       apif,
  input logic       ap_addr
);
  // R11
  irq_level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_lvl != 2'b00));

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe && !dif && !apif));

  // R7
  hold_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (dif || apif));

  // R6
  sda_moves_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R3
  addr_flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(apif) && ap_addr) |-> scl_oe);
endmodule

bind twb_slave twb_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .int_lvl(int_lvl), .irq(irq),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_s(scl_s), .dif(dif),
  .apif(apif), .ap_addr(ap_addr)
);

// File: tb/twb_slave_bench.sv
module twb_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [2:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_line, sda_line;

  int total = 0, bad = 0;
  bit done = 0;
  bit mdl_on = 0;
  logic exp_hold = 0, exp_irq = 0;

  always #2 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  twb_slave u_twb_slave (
    .clk(clk), .rst_n(rst_n), .bus_scl_i(scl_line), .bus_sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // per-clock model comparison of the hold line and interrupt (R7, R11)
  always @(negedge clk) begin
    if (mdl_on) begin
      total++;
      if (scl_oe !== exp_hold || irq !== exp_irq) begin
        bad++;
        $display("FAIL R11/R7 model: hold=%0b irq=%0b expected hold=%0b irq=%0b",
                 scl_oe, irq, exp_hold, exp_irq);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe(logic h, logic i);
    exp_hold = h; exp_irq = i; mdl_on = 1;
    tick(4);
    mdl_on = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_sel = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; wait_high(); tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; wait_high(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic m_rel(logic b);
    m_sda = b; tick(Q); m_scl = 1'b1;
  endtask

  task automatic m_fin(output logic r);
    wait_high(); tick(Q); r = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_bit(logic b, output logic r);
    m_rel(b); m_fin(r);
  endtask

  task automatic m_byte(logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
  endtask

  // first bit already released by m_rel; finishes it and reads 7 more
  task automatic m_getbyte(output logic [7:0] v);
    logic r;
    m_fin(r); v[7] = r;
    for (int i = 6; i >= 0; i--) begin m_bit(1'b1, r); v[i] = r; end
  endtask

  initial begin
    logic [7:0] v;
    logic b;
    tick(3); rst_n = 1'b1; tick(4);

    // R1 reset state
    rd(3'd0, v); check("R1 CTRLA", v, 8'h00);
    rd(3'd1, v); check("R1 CTRLB", v, 8'h00);
    rd(3'd2, v); check("R1 STATUS", v, 8'h00);
    check("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);

    // configuration, R2 layout, R3 address readback
    wr(3'd3, 8'h42);
    rd(3'd3, v); check("R3 ADDR readback", v, 8'h42);
    wr(3'd0, 8'h7C);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); check("R2 CTRLB read", v, 8'h04);
    rd(3'd2, v); check("R2 idle command no effect", v, 8'h00);
    wr(3'd1, 8'h00);

    // R3 own address write, acknowledge R6
    m_start(); m_byte(8'h84); m_rel(1'b1); tick(10);
    observe(1'b1, 1'b1);
    rd(3'd2, v); check("R3 STATUS on match", v, 8'h16);
    wr(3'd1, 8'h03);
    m_fin(b); check("R6 ack driven", b, 1'b0);

    // R7 receive, R8 smart off, R6 nack
    m_byte(8'hA5); m_rel(1'b1); tick(10);
    observe(1'b1, 1'b1);
    rd(3'd2, v); check("R7 STATUS after byte", v, 8'h15);
    rd(3'd4, v); check("R7 DATA", v, 8'hA5);
    tick(4); check("R8 read without smart keeps hold", scl_oe, 1'b1);
    wr(3'd1, 8'h04);
    wr(3'd2, 8'h01);
    m_fin(b); check("R6 nack", b, 1'b1);
    rd(3'd2, v); check("R7 DIF cleared", v, 8'h10);

    // R10 stop flag, R11
    m_stop(); tick(6);
    observe(1'b0, 1'b1);
    rd(3'd2, v); check("R10 STATUS on stop", v, 8'h02);
    wr(3'd2, 8'h02); tick(2);
    check("R11 irq after clear", irq, 1'b0);

    // R4 non-matching address
    wr(3'd1, 8'h00);
    m_start(); m_byte(8'h90); m_rel(1'b1); tick(10);
    observe(1'b0, 1'b0);
    rd(3'd2, v); check("R4 no flag", v, 8'h00);
    m_fin(b); check("R4 not acked", b, 1'b1);
    // R11 gating by level
    wr(3'd0, 8'h3C);
    m_stop(); tick(6);
    observe(1'b0, 1'b0);
    rd(3'd2, v); check("R11 flag set level zero", v, 8'h02);
    wr(3'd0, 8'h7C); tick(2);
    check("R11 irq with level", irq, 1'b1);
    wr(3'd2, 8'h02);

    // R5 promiscuous, R8 smart
    wr(3'd0, 8'h7F);
    m_start(); m_byte(8'h90); m_rel(1'b1); tick(10);
    observe(1'b1, 1'b1);
    rd(3'd2, v); check("R5 STATUS", v, 8'h16);
    wr(3'd1, 8'h03);
    m_fin(b); check("R5 acked", b, 1'b0);
    m_byte(8'h3C); m_rel(1'b1); tick(10);
    rd(3'd2, v); check("R8 STATUS", v, 8'h15);
    rd(3'd4, v); check("R8 DATA", v, 8'h3C);
    tick(4); check("R8 smart read releases", scl_oe, 1'b0);
    m_fin(b); check("R8 ack after smart read", b, 1'b0);

    // R9 repeated start into a read transfer
    m_start(); m_byte(8'h85); m_rel(1'b1); tick(10);
    rd(3'd2, v); check("R9 STATUS read addr", v, 8'h1E);
    wr(3'd1, 8'h03);
    m_fin(b); check("R9 addr acked", b, 1'b0);
    m_rel(1'b1); tick(10);
    observe(1'b1, 1'b1);
    rd(3'd2, v); check("R9 STATUS tx hold", v, 8'h1D);
    wr(3'd4, 8'hC3);
    m_getbyte(v); check("R9 byte one", v, 8'hC3);
    m_bit(1'b0, b);
    m_rel(1'b1); tick(10);
    rd(3'd2, v); check("R9 STATUS second hold", v, 8'h1D);
    wr(3'd4, 8'h5A);
    m_getbyte(v); check("R9 byte two", v, 8'h5A);
    m_bit(1'b1, b); tick(6);
    rd(3'd2, v); check("R9 master refusal", v, 8'h38);
    // R10 stop without stop flag enable
    wr(3'd0, 8'h7B);
    m_stop(); tick(6);
    rd(3'd2, v); check("R10 no flag without enable", v, 8'h28);

    // R12 disable during hold
    wr(3'd0, 8'h7C);
    m_start(); m_byte(8'h84); m_rel(1'b1); tick(10);
    check("R12 held before disable", scl_oe, 1'b1);
    wr(3'd0, 8'h74); tick(3);
    check("R12 lines released", {scl_oe, sda_oe, irq}, 3'b000);
    rd(3'd2, v); check("R12 STATUS zero", v, 8'h00);
    m_fin(b); check("R12 no ack", b, 1'b1);
    m_stop(); tick(4);

    done = 1;
    summary();
  end
endmodule